// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This unit sits between an execute stage and a 32-bit, word-addressed data memory. Each request carries a base register value, a signed 12-bit displacement, an access size, a signedness flag, a direction and store data. The unit forms the effective address, selects the byte lanes the access touches, and moves store bytes onto those lanes. On loads it gathers the addressed bytes back into the low end of the result and widens them with sign or zero fill.

Any halfword or word access may sit at any byte address. When the bytes of an access spill past the end of a memory word, the unit issues two word transactions, the containing word first and then the following word. It joins the two halves in little-endian order, so misalignment never raises an exception. The memory answers through a simple ready handshake: a transaction completes in the cycle where the request and ready are both high, and read data is valid in that same cycle.

A new request is accepted only while the unit is idle. Every accepted request, load or store, produces one response pulse.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is the base plus the 12-bit displacement sign-extended to 32 bits, modulo 2^32. The first memory transaction targets word address ea[31:2].
- R2: A byte access (size code 2'b00) enables only lane ea[1:0] and completes in a single transaction.
- R3: Store byte k of req_wdata is driven on the lane that holds address ea+k. Only the lanes of addressed bytes are enabled, so other bytes of the memory word are left unchanged.
- R4: A signed byte or halfword load (req_unsigned=0, size code 2'b00 or 2'b01) returns the loaded value sign-extended to 32 bits.
- R5: An unsigned byte or halfword load (req_unsigned=1) returns the loaded value zero-extended to 32 bits.
- R6: A word load (size code 2'b10) returns all four bytes, with the byte at the lowest address as the least significant byte of the result.
- R7: An access whose bytes cross a word boundary uses two transactions. The first goes to ea[31:2] with lanes ea[1:0] and up. The second goes to ea[31:2]+1 (wrapping) with the remaining lanes counted up from lane 0. The load result merges both in little-endian order.
- R8: An access that fits inside one memory word uses exactly one transaction.
- R9: busy is high from the cycle after a crossing access is accepted until its second transaction completes. It stays low for single-transaction accesses and after reset.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_addr, mem_be and mem_wdata hold their values into the next cycle.
- R11: resp_valid is high for one cycle, in the cycle after the final transaction of a request completes. A store response carries zero data. req_ready is high only when no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed displacement |
| req_wdata | input | 32 | Store data, byte 0 least significant |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | 32 | Extended load result (zero for stores) |
| busy | output | 1 | Crossing access in progress |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Memory word address |
| mem_be | output | 4 | Memory byte lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
Some properties are checked on every cycle. Request signals must hold through a stalled handshake. A byte access must have one lane and never cross. The count of enabled lanes must match the size, and an aligned start must never split. The second word of a crossing access must be the first word plus one. A response must follow a completed handshake, busy may only fall together with a response, and narrow loads must carry the correct fill bits. Whether the right bytes are gathered in the right order, whether stores land on the right lanes and spare their neighbours, and whether address wrap and negative displacements behave correctly can only be shown by the bench. It does this by comparing every transaction and response against a byte-level model, with and without memory stalls.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
    localparam int XLEN    = 32;
    localparam int OFF_W   = 12;
    localparam int LANES   = XLEN / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WADDR_W = XLEN - LANE_W;
    localparam int SHAMT_W = LANE_W + 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              store;
        size_e             size;
        logic              unsgn;
        logic [XLEN-1:0]   ea;
        logic [XLEN-1:0]   wdata;
    } access_t;

    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [LANES-1:0]   be_lo;
        logic [LANES-1:0]   be_hi;
        logic [XLEN-1:0]    wd_lo;
        logic [XLEN-1:0]    wd_hi;
        logic               split;
    } lane_plan_t;

    function automatic logic [LANES-1:0] size_mask(input size_e sz);
        logic [LANES-1:0] m;
        m = '0;
        case (sz)
            SZ_BYTE: m[0]   = 1'b1;
            SZ_HALF: m[1:0] = 2'b11;
            default: m      = '1;
        endcase
        return m;
    endfunction

    function automatic int size_bytes(input size_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return LANES;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] raw,
                                              input size_e sz,
                                              input logic unsgn);
        logic [XLEN-1:0] r;
        case (sz)
            SZ_BYTE: r = {{(XLEN-8){raw[7] & ~unsgn}}, raw[7:0]};
            SZ_HALF: r = {{(XLEN-16){raw[15] & ~unsgn}}, raw[15:0]};
            default: r = raw;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc import lsu_pkg::*; (
    input  logic [XLEN-1:0]  base,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  ea
);
    localparam int EXT_W = XLEN - OFF_W;

    assign ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};
endmodule

// File: rtl/lsu_lane_plan.sv
module lsu_lane_plan import lsu_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic [XLEN-1:0] ea,
    input  size_e           size,
    input  logic [XLEN-1:0] wdata,
    output lane_plan_t      plan
);
    logic [LANE_W-1:0]  offs;
    logic [SHAMT_W-1:0] bit_shift;
    logic [2*LANES-1:0] mask2;
    logic [2*XLEN-1:0]  data2;

    always_comb begin
        offs      = ea[LANE_W-1:0];
        bit_shift = {offs, 3'b000};
        mask2     = {{LANES{1'b0}}, size_mask(size)} << offs;
        data2     = {{XLEN{1'b0}}, wdata} << bit_shift;
        plan.waddr = ea[XLEN-1:LANE_W];
        plan.be_lo = mask2[LANES-1:0];
        plan.be_hi = mask2[2*LANES-1:LANES];
        plan.wd_lo = data2[XLEN-1:0];
        plan.wd_hi = data2[2*XLEN-1:XLEN];
        plan.split = |mask2[2*LANES-1:LANES];
    end

    assert_byte_lane_R2: assert property (@(posedge clk) disable iff (rst)
        (active && size == SZ_BYTE) |-> ($onehot(plan.be_lo) && plan.be_hi == '0));

    assert_lane_count_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> ($countones({plan.be_hi, plan.be_lo}) == size_bytes(size)));

    assert_aligned_single_R8: assert property (@(posedge clk) disable iff (rst)
        (active && ea[LANE_W-1:0] == '0) |-> !plan.split);
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge import lsu_pkg::*; (
    input  logic [XLEN-1:0]   lo_word,
    input  logic [XLEN-1:0]   hi_word,
    input  logic [LANE_W-1:0] offs,
    input  size_e             size,
    input  logic              unsgn,
    output logic [XLEN-1:0]   result
);
    logic [2*XLEN-1:0]  pair;
    logic [SHAMT_W-1:0] bit_shift;

    always_comb begin
        bit_shift = {offs, 3'b000};
        pair      = {hi_word, lo_word} >> bit_shift;
        result    = widen(pair[XLEN-1:0], size, unsgn);
    end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq import lsu_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       split,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       mem_req,
    output logic       hs_first_split,
    output logic       hs_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_FIRST;
                ST_FIRST:  if (mem_ready) state <= split ? ST_SECOND : ST_IDLE;
                ST_SECOND: if (mem_ready) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req        = (state != ST_IDLE);
    assign hs_first_split = (state == ST_FIRST) && mem_ready && split;
    assign hs_last        = mem_ready &&
                            ((state == ST_SECOND) || (state == ST_FIRST && !split));

    assert_wait_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(state)));
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit import lsu_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic                req_unsigned,
    input  logic [XLEN-1:0]     req_base,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [XLEN-1:0]     req_wdata,
    output logic                resp_valid,
    output logic [XLEN-1:0]     resp_rdata,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]    mem_be,
    output logic [XLEN-1:0]     mem_wdata,
    input  logic                mem_ready,
    input  logic [XLEN-1:0]     mem_rdata
);
    seq_state_e      state;
    logic            start;
    logic            hs_first_split;
    logic            hs_last;
    logic            second;
    logic [XLEN-1:0] ea;
    access_t         acc_q;
    lane_plan_t      plan;
    logic [XLEN-1:0] lo_q;
    logic [XLEN-1:0] merge_lo;
    logic [XLEN-1:0] merge_hi;
    logic [XLEN-1:0] load_val;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;
    assign second    = (state == ST_SECOND);

    lsu_ea_calc u_ea (
        .base   (req_base),
        .offset (req_offset),
        .ea     (ea)
    );

    lsu_lane_plan u_plan (
        .clk    (clk),
        .rst    (rst),
        .active (state != ST_IDLE),
        .ea     (acc_q.ea),
        .size   (acc_q.size),
        .wdata  (acc_q.wdata),
        .plan   (plan)
    );

    lsu_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .split          (plan.split),
        .mem_ready      (mem_ready),
        .state          (state),
        .mem_req        (mem_req),
        .hs_first_split (hs_first_split),
        .hs_last        (hs_last)
    );

    assign merge_lo = plan.split ? lo_q : mem_rdata;
    assign merge_hi = plan.split ? mem_rdata : '0;

    lsu_load_merge u_merge (
        .lo_word (merge_lo),
        .hi_word (merge_hi),
        .offs    (acc_q.ea[LANE_W-1:0]),
        .size    (acc_q.size),
        .unsgn   (acc_q.unsgn),
        .result  (load_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            lo_q       <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            if (start) begin
                acc_q.store <= req_store;
                acc_q.size  <= size_e'(req_size);
                acc_q.unsgn <= req_unsigned;
                acc_q.ea    <= ea;
                acc_q.wdata <= req_wdata;
            end
            if (hs_first_split) lo_q <= mem_rdata;
            resp_valid <= hs_last;
            if (hs_last) resp_rdata <= acc_q.store ? '0 : load_val;
        end
    end

    always_comb begin
        mem_we    = acc_q.store;
        mem_addr  = second ? plan.waddr + 1'b1 : plan.waddr;
        mem_be    = second ? plan.be_hi : plan.be_lo;
        mem_wdata = second ? plan.wd_hi : plan.wd_lo;
        busy      = second || (state == ST_FIRST && plan.split);
    end

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_be) && $stable(mem_wdata)));

    assert_next_word_R7: assert property (@(posedge clk) disable iff (rst)
        (second && $past(state) == ST_FIRST) |-> (mem_addr == $past(mem_addr) + 1'b1));

    assert_resp_after_hs_R11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(mem_req && mem_ready));

    assert_busy_ends_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> resp_valid);

    assert_sign_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !acc_q.store && !acc_q.unsgn && acc_q.size == SZ_BYTE)
            |-> (resp_rdata[XLEN-1:8] == {(XLEN-8){resp_rdata[7]}}));

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !acc_q.store && acc_q.unsgn && acc_q.size == SZ_HALF)
            |-> (resp_rdata[XLEN-1:16] == '0));
endmodule

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk;

    lsu_lane_unit uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_offset(req_offset), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [29:0] waddr;
        logic [3:0]  be;
        logic        we;
        logic [31:0] wdata;
        logic        split;
    } txn_t;

    txn_t        txq[$];
    logic [31:0] rspq[$];
    string       rsp_tag[$];

    logic [31:0] mem_w [16];
    logic [7:0]  shadow [64];
    logic [7:0]  lfsr = 8'h5A;
    bit          stall_mode = 1'b0;
    int          total = 0;
    int          bad = 0;

    assign mem_rdata = mem_w[mem_addr[3:0]];

    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= !stall_mode || lfsr[0] || lfsr[3];
        if (mem_req && mem_ready && mem_we)
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem_w[mem_addr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int l = 0; l < 4; l++) if (be[l]) m[8*l +: 8] = 8'hFF;
        return m;
    endfunction

    // monitor: compares every handshake and response against the queues
    txn_t        mon_t;
    logic [31:0] mon_exp;
    string       mon_tag;
    bit          hold_pend = 1'b0;
    logic [29:0] hold_addr;
    logic [3:0]  hold_be;
    logic [31:0] hold_wd;

    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend) begin
                check(mem_req && mem_addr == hold_addr && mem_be == hold_be &&
                      mem_wdata == hold_wd, "R10", "stalled request held",
                      {2'b0, mem_addr}, {2'b0, hold_addr});
            end
            hold_pend = mem_req && !mem_ready;
            hold_addr = mem_addr;
            hold_be   = mem_be;
            hold_wd   = mem_wdata;
            if (mem_req && mem_ready) begin
                if (txq.size() == 0) begin
                    check(1'b0, "R8", "unexpected transaction", {2'b0, mem_addr}, 32'h0);
                end else begin
                    mon_t = txq.pop_front();
                    check(mem_addr == mon_t.waddr, mon_t.split ? "R7" : "R1", "word address",
                          {2'b0, mem_addr}, {2'b0, mon_t.waddr});
                    check(mem_be == mon_t.be, mon_t.split ? "R7" : "R2", "byte enables",
                          {28'b0, mem_be}, {28'b0, mon_t.be});
                    check(mem_we == mon_t.we, "R11", "direction", {31'b0, mem_we}, {31'b0, mon_t.we});
                    if (mon_t.we)
                        check((mem_wdata & lane_mask(mon_t.be)) == (mon_t.wdata & lane_mask(mon_t.be)),
                              "R3", "store lanes", mem_wdata & lane_mask(mon_t.be),
                              mon_t.wdata & lane_mask(mon_t.be));
                    check(busy == mon_t.split, "R9", "busy during transaction",
                          {31'b0, busy}, {31'b0, mon_t.split});
                end
            end
            if (resp_valid) begin
                if (rspq.size() == 0) begin
                    check(1'b0, "R11", "unexpected response", resp_rdata, 32'h0);
                end else begin
                    mon_exp = rspq.pop_front();
                    mon_tag = rsp_tag.pop_front();
                    check(resp_rdata == mon_exp, mon_tag, "response data", resp_rdata, mon_exp);
                end
            end
        end
    end

    // driver: computes expectations byte by byte, then issues the request
    task automatic do_access(input bit st, input logic [1:0] sz, input bit uns,
                             input logic [31:0] base, input logic [11:0] off,
                             input logic [31:0] wd, input string tag);
        logic [31:0] ea;
        logic [31:0] a;
        logic [31:0] v;
        logic [3:0]  be0, be1;
        logic [31:0] wd0, wd1;
        txn_t        t;
        int          n;
        ea  = base + {{20{off[11]}}, off};
        n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        be0 = '0; be1 = '0; wd0 = '0; wd1 = '0; v = '0;
        for (int k = 0; k < n; k++) begin
            a = ea + k;
            if (a[31:2] == ea[31:2]) begin
                be0[a[1:0]] = 1'b1;
                wd0[8*a[1:0] +: 8] = wd[8*k +: 8];
            end else begin
                be1[a[1:0]] = 1'b1;
                wd1[8*a[1:0] +: 8] = wd[8*k +: 8];
            end
            if (st) shadow[a[5:0]] = wd[8*k +: 8];
            else    v[8*k +: 8] = shadow[a[5:0]];
        end
        if (!st && sz == 2'b00) v = uns ? {24'b0, v[7:0]} : {{24{v[7]}}, v[7:0]};
        if (!st && sz == 2'b01) v = uns ? {16'b0, v[15:0]} : {{16{v[15]}}, v[15:0]};
        t.waddr = ea[31:2]; t.be = be0; t.we = st; t.wdata = wd0; t.split = (be1 != 0);
        txq.push_back(t);
        if (be1 != 0) begin
            t.waddr = ea[31:2] + 30'd1; t.be = be1; t.wdata = wd1;
            txq.push_back(t);
        end
        rspq.push_back(st ? 32'h0 : v);
        rsp_tag.push_back(tag);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
        req_base = base; req_offset = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_w[i] = 32'h0;
            for (int l = 0; l < 4; l++) shadow[4*i + l] = 8'h0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_req && !resp_valid, "R11", "reset state idle",
              {29'b0, req_ready, mem_req, resp_valid}, 32'h4);
        check(!busy, "R9", "busy low after reset", {31'b0, busy}, 32'h0);

        // fill memory with aligned word stores (R1, R3)
        for (int i = 0; i < 16; i++)
            do_access(1'b1, 2'b10, 1'b0, 32'h0, 12'(4*i), 32'h80706050 + i*32'h1F3D5B79, "R11");
        // byte loads at every lane, signed (R4) and unsigned (R5)
        for (int i = 0; i < 8; i++) begin
            do_access(1'b0, 2'b00, 1'b0, 32'h10, 12'(i), 32'h0, "R4");
            do_access(1'b0, 2'b00, 1'b1, 32'h10, 12'(i), 32'h0, "R5");
        end
        // halfword loads at every offset, offset 3 crosses (R7)
        for (int j = 0; j < 4; j++) begin
            do_access(1'b0, 2'b01, 1'b0, 32'h20, 12'(j), 32'h0, (j == 3) ? "R7" : "R4");
            do_access(1'b0, 2'b01, 1'b1, 32'h20, 12'(j), 32'h0, (j == 3) ? "R7" : "R5");
        end
        // word loads at every offset (R6, R7)
        for (int j = 0; j < 4; j++)
            do_access(1'b0, 2'b10, 1'b0, 32'h30, 12'(j), 32'h0, (j == 0) ? "R6" : "R7");
        // narrow and misaligned stores, then read back (R2, R3, R7)
        do_access(1'b1, 2'b00, 1'b0, 32'h08, 12'd1, 32'hFFFFFF11, "R2");
        do_access(1'b1, 2'b00, 1'b0, 32'h08, 12'd3, 32'h00000022, "R2");
        do_access(1'b1, 2'b01, 1'b0, 32'h0C, 12'd3, 32'hABCD9988, "R7");
        do_access(1'b1, 2'b10, 1'b0, 32'h14, 12'd2, 32'hCAFE1234, "R7");
        for (int i = 2; i < 7; i++)
            do_access(1'b0, 2'b10, 1'b0, 32'h0, 12'(4*i), 32'h0, "R3");
        // negative displacement (R1)
        do_access(1'b0, 2'b10, 1'b0, 32'h28, 12'hFFD, 32'h0, "R1");
        do_access(1'b0, 2'b00, 1'b1, 32'h04, 12'h800, 32'h0, "R1");
        // address wrap across the top of the space (R7)
        do_access(1'b1, 2'b10, 1'b0, 32'hFFFFFFFE, 12'h0, 32'h5A6B7C8D, "R7");
        do_access(1'b0, 2'b10, 1'b0, 32'hFFFFFFFC, 12'h2, 32'h0, "R7");
        do_access(1'b0, 2'b10, 1'b0, 32'h0, 12'h0, 32'h0, "R6");
        // memory stalls with mixed traffic (R10)
        stall_mode = 1'b1;
        for (int i = 0; i < 24; i++) begin
            do_access(1'b1, 2'(i % 3), 1'b0, 32'h40, 12'(i), 32'h13579BDF ^ (i * 32'h01020304), "R10");
            do_access(1'b0, 2'(i % 3), 1'(i % 2), 32'h40, 12'(i), 32'h0, "R10");
        end
        stall_mode = 1'b0;
        repeat (12) @(negedge clk);
        check(txq.size() == 0 && rspq.size() == 0, "R11", "all expected items seen",
              txq.size() + rspq.size(), 32'h0);
        finish_run();
    end
endmodule